// File: doc/BRIEF.md
# Multichannel I2S Transmit Serializer

This block turns a stream of interleaved PCM samples into serial audio on up to four data lanes. Each lane carries one channel pair, left then right. It does not generate clocks. A separate generator supplies a bit-clock enable strobe and a frame strobe. Each frame lasts 64 bit-clock slots, 32 for each half. Samples enter through a ready/valid handshake. Every frame consumes one sample for each active channel, in channel order.

A descriptor selects two or eight channels and a 16-bit or 32-bit sample container. The descriptor changes only on a soft reset pulse. That pulse also flushes every buffered sample and all output state. A hold input stops intake and mutes the lanes without dropping any buffered sample. Output resumes at the first frame that starts with hold low. If a frame starts before all of its samples are buffered, a sticky underflow flag is set and that frame goes out as zeros.

Top module: `i2s_lane_serializer`

## Requirements
- R1: After `rst_n` is released, `desc` reads 4'b1000 (two channels, 16-bit container), every lane is 0, `underflow` is 0 and `in_ready` is 1 while `hold` and `soft_rst` are low.
- R2: `desc` bit 0 means eight channels. Bits 1 and 2 are both set for the 32-bit container and both clear for the 16-bit container. Bit 3 is always 1. A soft reset loads the descriptor only when `cfg_chans` is 2 or 8 and `cfg_bits` is 16 or 32. Otherwise the whole previous descriptor is kept.
- R3: On any cycle without `soft_rst`, `cfg_chans` and `cfg_bits` have no effect on `desc`.
- R4: A cycle with `soft_rst` high discards all buffered samples and clears `underflow`. From the next cycle all lanes read 0 until a frame is loaded.
- R5: `in_ready` is high exactly when `hold` is low, `soft_rst` is low and fewer samples are buffered than the active channel count. A sample is taken on a clock where `in_valid` and `in_ready` are both high.
- R6: A frame starts on a clock where `bclk_en` and `fs_strobe` are both high. If the buffer holds a full frame and `hold` is low, the frame is loaded. From the next cycle a lane shows the MSB of its left sample, and each later `bclk_en` advances one slot. Slot 32 starts the right sample, and slots past 63 read 0.
- R7: In eight-channel mode, channels 2k and 2k+1 (arrival order within a frame) go to lane k for k = 0..3. In two-channel mode, only lane 0 carries data and lanes 1 to 3 stay 0.
- R8: With the 32-bit container, `in_data[31:0]` fills a half-frame MSB first. With the 16-bit container, `in_data[15:0]` fills the first 16 slots of its half and the remaining 16 slots are 0.
- R9: While `hold` is high, no sample is taken. All lanes read 0 from the cycle after `hold` is first seen high. A frame start under hold consumes nothing, and output resumes at the first frame start seen with `hold` low.
- R10: A frame start with `hold` low and an incomplete buffer sets `underflow`. The flag stays set until a soft reset. That frame is sent as zeros, and the samples already buffered stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Pipeline flush pulse; the only time the descriptor loads |
| cfg_chans | input | 4 | Requested channel count (2 or 8) |
| cfg_bits | input | 6 | Requested container width (16 or 32) |
| bclk_en | input | 1 | One-cycle strobe per bit-clock slot |
| fs_strobe | input | 1 | Marks the first slot of a frame (qualified by `bclk_en`) |
| hold | input | 1 | Stop intake and mute output |
| in_data | input | 32 | Sample word |
| in_valid | input | 1 | Sample word valid |
| in_ready | output | 1 | Serializer can take a sample |
| sd | output | 4 | Serial data, one bit per lane |
| underflow | output | 1 | Sticky frame-underflow flag |
| desc | output | 4 | Active mode descriptor |

## Verification
The bench feeds the serializer in every container and channel mode and follows a behavioural frame model slot by slot. A wrong lane map or a wrong 16-bit padding therefore shows up as a single bad bit on one lane. Descriptor writes are tried with illegal counts and without a reset pulse. A design that updates one field of an illegal request, or that tracks the config pins live, would show a changed `desc`. Hold is raised in the middle of a frame and released later. A design that drops buffered samples, or that resumes mid-frame, would shift the channel order seen on the lanes. Starving the input checks that the underflow frame is zero and the flag sticks, and a later soft reset must clear it.

// File: rtl/i2s_lane_serializer.sv
module i2s_lane_serializer #(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [3:0]       cfg_chans,
  input  logic [5:0]       cfg_bits,
  input  logic             bclk_en,
  input  logic             fs_strobe,
  input  logic             hold,
  input  logic [DW-1:0]    in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [LANES-1:0] sd,
  output logic             underflow,
  output logic [3:0]       desc
);
  localparam int CH_MAX = 2 * LANES;
  localparam int CW     = $clog2(CH_MAX + 1);
  localparam int IW     = $clog2(CH_MAX);
  localparam int FW     = 2 * DW;
  localparam int NARROW = 16;

  logic          ch8, w32, muted;
  logic [CW-1:0] fill;
  logic [DW-1:0] sbuf [CH_MAX];

  wire [CW-1:0] nch    = ch8 ? CW'(CH_MAX) : CW'(2);
  wire          fstart = bclk_en & fs_strobe;
  wire          full   = (fill == nch);
  wire          cfg_ok = (cfg_chans == 4'd2 || cfg_chans == 4'd8) &&
                         (cfg_bits == 6'd16 || cfg_bits == 6'd32);
  wire          take   = in_valid & in_ready;
  wire          launch = fstart & ~hold & ~soft_rst & full;

  assign in_ready = ~hold & ~soft_rst & ~full;
  assign desc     = {1'b1, w32, w32, ch8};

  function automatic logic [DW-1:0] fmt(input logic [DW-1:0] x);
    return w32 ? x : {x[NARROW-1:0], {(DW-NARROW){1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch8 <= 1'b0;
      w32 <= 1'b0;
    end else if (soft_rst && cfg_ok) begin
      ch8 <= (cfg_chans == 4'd8);
      w32 <= (cfg_bits == 6'd32);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill      <= '0;
      underflow <= 1'b0;
      muted     <= 1'b0;
    end else begin
      if (soft_rst) begin
        fill      <= '0;
        underflow <= 1'b0;
      end else begin
        if (launch)    fill <= '0;
        else if (take) fill <= fill + 1'b1;
        if (fstart && !hold && !full) underflow <= 1'b1;
      end
      if (hold)        muted <= 1'b1;
      else if (fstart) muted <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) sbuf[fill[IW-1:0]] <= in_data;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic      shr_lane_act;
    logic [FW-1:0] shr;
    assign shr_lane_act = (l == 0) || ch8;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                shr <= '0;
      else if (soft_rst)         shr <= '0;
      else if (fstart)           shr <= (launch && shr_lane_act) ?
                                        {fmt(sbuf[2*l]), fmt(sbuf[2*l+1])} : '0;
      else if (bclk_en)          shr <= shr << 1;
    end

    assign sd[l] = shr[FW-1] & ~muted;

    if (l > 0) begin : g_idle_chk
      a_r7_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !ch8 |-> !sd[l]);
    end
  end

  a_r3_desc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> $stable(desc));

  a_r9_hold_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (sd == '0));

  a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (fill == '0 && !underflow && sd == '0));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !soft_rst) |=> underflow);

  a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= nch);
endmodule

// File: tb/tb_i2s_lane_serializer.sv
module tb_i2s_lane_serializer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        soft_rst = 0;
  logic [3:0]  cfg_chans = 4'd2;
  logic [5:0]  cfg_bits = 6'd16;
  logic        bclk_en = 0, fs_strobe = 0, hold = 0;
  logic [31:0] in_data = 0;
  logic        in_valid = 0;
  logic        in_ready, underflow;
  logic [3:0]  sd, desc;

  i2s_lane_serializer dut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  string cur_req = "R6";

  // behavioural reference model
  bit          m_ch8, m_w32, m_muted, m_uflow;
  logic [31:0] pend[$];
  logic [63:0] frame [4];
  int          slot = 64;
  int          data_ctr = 0;

  function automatic logic [31:0] pat(input int n);
    return 32'(n * 32'h9E3779B1 + 32'h13572468);
  endfunction

  function automatic logic [31:0] shape(input logic [31:0] x, input bit wide);
    return wide ? x : {x[15:0], 16'h0};
  endfunction

  function automatic int m_nch();
    return m_ch8 ? 8 : 2;
  endfunction

  function automatic bit m_ready();
    return !hold && !soft_rst && (pend.size() < m_nch());
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ch8 = 0; m_w32 = 0; m_muted = 0; m_uflow = 0;
      pend.delete(); slot = 64;
      for (int l = 0; l < 4; l++) frame[l] = '0;
    end else begin
      bit acc, fst;
      acc = in_valid && m_ready();
      fst = bclk_en && fs_strobe;
      if (soft_rst) begin
        if ((cfg_chans == 2 || cfg_chans == 8) && (cfg_bits == 16 || cfg_bits == 32)) begin
          m_ch8 = (cfg_chans == 8);
          m_w32 = (cfg_bits == 32);
        end
        pend.delete();
        for (int l = 0; l < 4; l++) frame[l] = '0;
        slot = 64;
        m_uflow = 0;
      end else begin
        if (fst) begin
          for (int l = 0; l < 4; l++) frame[l] = '0;
          slot = 0;
          if (!hold) begin
            if (pend.size() == m_nch()) begin
              for (int l = 0; l < m_nch() / 2; l++)
                frame[l] = {shape(pend[2*l], m_w32), shape(pend[2*l+1], m_w32)};
              pend.delete();
            end else begin
              m_uflow = 1;
            end
          end
        end else if (bclk_en && slot < 64) begin
          slot++;
        end
        if (acc) begin
          pend.push_back(in_data);
          data_ctr++;
        end
      end
      if (hold) m_muted = 1;
      else if (fst) m_muted = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  bit bph = 0;
  int bitc = 0;

  task automatic step();
    logic [3:0] exp_sd;
    @(posedge clk);
    #2;
    bph = !bph;
    bclk_en = bph;
    fs_strobe = 0;
    if (bph) begin
      fs_strobe = (bitc == 0);
      bitc = (bitc + 1) % 64;
    end
    in_data = pat(data_ctr);
    #1;
    for (int l = 0; l < 4; l++)
      exp_sd[l] = m_muted ? 1'b0 : (slot < 64 ? frame[l][63 - slot] : 1'b0);
    check(cur_req, 32'(sd), 32'(exp_sd));
    check("R5", 32'(in_ready), 32'(m_ready()));
    check("R10", 32'(underflow), 32'(m_uflow));
    check("R2", 32'(desc), {28'h0, 1'b1, m_w32, m_w32, m_ch8});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_reset(input int ch, input int bits);
    cfg_chans = 4'(ch);
    cfg_bits = 6'(bits);
    soft_rst = 1;
    step();
    soft_rst = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1 reset state
    check("R1", 32'(desc), 32'h8);
    check("R1", 32'(sd), 32'h0);
    check("R1", 32'(underflow), 32'h0);
    check("R1", 32'(in_ready), 32'h1);

    in_valid = 1;
    cur_req = "R8";                 // 2 channels, 16-bit container
    run(3 * 128);

    pulse_reset(2, 32);
    check("R2", 32'(desc), 32'hE);
    cur_req = "R6";
    run(3 * 128);

    pulse_reset(8, 32);
    check("R2", 32'(desc), 32'hF);
    cur_req = "R7";
    run(3 * 128);

    pulse_reset(8, 16);
    check("R2", 32'(desc), 32'h9);
    cur_req = "R8";
    run(2 * 128);

    // R3: config pins without a pulse
    cfg_chans = 4'd2; cfg_bits = 6'd32;
    run(20);
    check("R3", 32'(desc), 32'h9);

    // R2: illegal requests leave the descriptor alone
    pulse_reset(4, 32);
    check("R2", 32'(desc), 32'h9);
    pulse_reset(8, 24);
    check("R2", 32'(desc), 32'h9);
    cur_req = "R7";
    run(2 * 128);

    // R9 hold mid-frame
    cur_req = "R9";
    run(37);
    hold = 1;
    run(2 * 128);
    check("R9", 32'(in_ready), 32'h0);
    check("R9", 32'(sd), 32'h0);
    hold = 0;
    run(3 * 128);

    // R10 starvation
    cur_req = "R10";
    in_valid = 0;
    run(2 * 128);
    check("R10", 32'(underflow), 32'h1);
    check("R10", 32'(sd), 32'h0);
    in_valid = 1;
    run(2 * 128);

    // R4 flush
    cur_req = "R4";
    pulse_reset(2, 16);
    check("R4", 32'(underflow), 32'h0);
    check("R4", 32'(sd), 32'h0);
    check("R4", 32'(desc), 32'h8);
    run(3 * 128);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule